// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Each accepted write stores a data word together with its parity bits in an internal memory array. Reads return them in the same order on the read clock. Each side sees only flags that are registered in its own clock domain. The write side gets full, almost-full, an error pulse and a wrapping pointer count. The read side gets empty, almost-empty, an error pulse and its own wrapping pointer count. The almost thresholds are parameters.

The write and read pointers carry one bit more than the address, so that a full buffer and an empty buffer can be told apart. Each pointer reaches the other domain as Gray code through a chain of synchronizer flops. A flag therefore asserts at once on its own side's access. It clears only a few cycles after the opposite side acts. One active-low reset is applied asynchronously to both domains and is released synchronously in each.

When the block is built for a single shared clock and the output register is selected, a second register stage sits after the memory read. That stage has its own clock enable and its own synchronous clear, and the clear wins over the enable. In every other build, those two inputs have no effect.

Top module: `xclk_fifo`

## Requirements
- R1: While `arst_n` is low, and until the first access after it is released, the outputs hold their reset values: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `wr_err`=0, `rd_err`=0, both counts 0, and `rd_data`/`rd_par` 0.
- R2: Words and their parity bits leave the buffer in the order they were accepted. Without the output register, `{rd_par, rd_data}` shows the word one `rd_clk` cycle after the edge that accepted the read.
- R3: `full` is high in the `wr_clk` cycle after the write that fills all 2^ADDR_W entries. A write while `full` is high is dropped: `wr_count` does not move, and the stored words are unchanged.
- R4: `wr_err` is high for exactly the one `wr_clk` cycle that follows each cycle in which `wr_en` was high while `full` was high. It is low at all other times.
- R5: `empty` is high when no word is stored. A read while `empty` is high is dropped: `rd_count` does not move. `rd_err` is high for exactly the `rd_clk` cycle after such a read, and low at all other times.
- R6: `almost_full` is high when the number of free entries, as seen by the write side, is less than `AFULL_GAP`. It is updated in the cycle after each accepted write.
- R7: `almost_empty` is high when the number of stored words, as seen by the read side, is less than `AEMPTY_GAP`. It is updated in the cycle after each accepted read.
- R8: `wr_count` and `rd_count` are the low ADDR_W bits of the write and read pointers. Each rises by one per accepted access and wraps from 2^ADDR_W-1 to 0.
- R9: Each pointer changes at most one bit per cycle in the form that crosses domains. `full` and `almost_full` clear within a few `wr_clk` cycles of enough reads. `empty` clears within a few `rd_clk` cycles of a write.
- R10: With `SINGLE_CLK`=1 and `OUT_REG`=1, a word appears two cycles after its read is accepted. While `oreg_ce` is low, the output holds. `oreg_rst` high zeroes the output on the next edge, even when `oreg_ce` is high.
- R11: In any other build, `oreg_ce` and `oreg_rst` have no effect on `rd_data` or `rd_par`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_par | input | PAR_W | Parity bits stored with the word |
| full | output | 1 | Every entry is occupied |
| almost_full | output | 1 | Free entries fewer than AFULL_GAP |
| wr_count | output | ADDR_W | Wrapping write pointer |
| wr_err | output | 1 | Pulse after a write refused because the buffer was full |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| oreg_ce | input | 1 | Output register clock enable |
| oreg_rst | input | 1 | Output register synchronous clear, wins over oreg_ce |
| rd_data | output | DATA_W | Word read out |
| rd_par | output | PAR_W | Parity bits read out |
| empty | output | 1 | No word stored |
| almost_empty | output | 1 | Stored words fewer than AEMPTY_GAP |
| rd_count | output | ADDR_W | Wrapping read pointer |
| rd_err | output | 1 | Pulse after a read refused because the buffer was empty |

## Verification
On every cycle, the assertions check the following:
- a refused write or read leaves its count still and raises its error pulse on the next cycle;
- an error pulse appears only after a refused access;
- full implies almost-full, and empty implies almost-empty;
- the counts move by at most one per cycle;
- the Gray-coded pointers change at most one bit per cycle.

Only the bench scenarios can show the rest:
- that words come out in order and with their parity;
- the exact fill levels at which the almost flags switch;
- the count wrap after a full lap;
- that flags clear after the other side acts;
- the two-cycle timing of the output register, with its hold and its clear-over-enable priority.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  // Binary to reflected Gray code on a 32-bit carrier; callers cast the width.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary; the unused upper bits of the carrier must be zero.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_rst_sync.sv
module xclk_fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
module xclk_fifo_wr_ctl #(
  parameter int ADDR_W    = 4,
  parameter int AFULL_GAP = 4,
  localparam int PTR_W    = ADDR_W + 1,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  rgray_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0]  wgray,
  output logic              full,
  output logic              almost_full,
  output logic [ADDR_W-1:0] wr_count,
  output logic              wr_err
);
  import xclk_fifo_pkg::*;

  logic [PTR_W-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, used_d;
  logic             full_q, full_d, afull_q, afull_d, err_q, err_d;
  logic             accept;

  // next-state
  always_comb begin
    accept  = wr_en & ~full_q;
    wbin_d  = wbin_q + PTR_W'(accept);
    wgray_d = PTR_W'(bin2gray(32'(wbin_d)));
    rbin_s  = PTR_W'(gray2bin(32'(rgray_sync)));
    used_d  = wbin_d - rbin_s;
    full_d  = (used_d == PTR_W'(DEPTH));
    afull_d = ((PTR_W'(DEPTH) - used_d) < PTR_W'(AFULL_GAP));
    err_d   = wr_en & full_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      afull_q <= afull_d;
      err_q   <= err_d;
    end
  end

  assign mem_we      = accept;
  assign mem_waddr   = wbin_q[ADDR_W-1:0];
  assign wgray       = wgray_q;
  assign full        = full_q;
  assign almost_full = afull_q;
  assign wr_count    = wbin_q[ADDR_W-1:0];
  assign wr_err      = err_q;
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
module xclk_fifo_rd_ctl #(
  parameter int ADDR_W     = 4,
  parameter int AEMPTY_GAP = 4,
  localparam int PTR_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  wgray_sync,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [PTR_W-1:0]  rgray,
  output logic              empty,
  output logic              almost_empty,
  output logic [ADDR_W-1:0] rd_count,
  output logic              rd_err
);
  import xclk_fifo_pkg::*;

  logic [PTR_W-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, stored_d;
  logic             empty_q, empty_d, aempty_q, aempty_d, err_q, err_d;
  logic             accept;

  // next-state
  always_comb begin
    accept   = rd_en & ~empty_q;
    rbin_d   = rbin_q + PTR_W'(accept);
    rgray_d  = PTR_W'(bin2gray(32'(rbin_d)));
    wbin_s   = PTR_W'(gray2bin(32'(wgray_sync)));
    stored_d = wbin_s - rbin_d;
    empty_d  = (stored_d == '0);
    aempty_d = (stored_d < PTR_W'(AEMPTY_GAP));
    err_d    = rd_en & empty_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
      err_q    <= err_d;
    end
  end

  assign mem_re       = accept;
  assign mem_raddr    = rbin_q[ADDR_W-1:0];
  assign rgray        = rgray_q;
  assign empty        = empty_q;
  assign almost_empty = aempty_q;
  assign rd_count     = rbin_q[ADDR_W-1:0];
  assign rd_err       = err_q;
endmodule

// File: rtl/xclk_fifo_ram.sv
module xclk_fifo_ram #(
  parameter int W      = 18,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q, rdata_d;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb rdata_d = re ? mem[raddr] : rdata_q;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xclk_fifo_ostage.sv
module xclk_fifo_ostage #(
  parameter int W  = 18,
  parameter bit EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (EN) begin : g_reg
    logic [W-1:0] q_q, q_d;
    // clear wins over enable
    always_comb begin
      if (srst)    q_d = '0;
      else if (ce) q_d = d;
      else         q_d = q_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= '0;
      else        q_q <= q_d;
    end
    assign q = q_q;
  end else begin : g_bypass
    logic unused_ok;
    assign unused_ok = ^{clk, rst_n, ce, srst};
    assign q = d;
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W      = 16,
  parameter int PAR_W       = 2,
  parameter int ADDR_W      = 4,
  parameter int AFULL_GAP   = 4,
  parameter int AEMPTY_GAP  = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit SINGLE_CLK  = 1'b0,
  parameter bit OUT_REG     = 1'b0
) (
  input  logic              arst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAR_W-1:0]  wr_par,
  output logic              full,
  output logic              almost_full,
  output logic [ADDR_W-1:0] wr_count,
  output logic              wr_err,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic              oreg_ce,
  input  logic              oreg_rst,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAR_W-1:0]  rd_par,
  output logic              empty,
  output logic              almost_empty,
  output logic [ADDR_W-1:0] rd_count,
  output logic              rd_err
);
  localparam int PTR_W    = ADDR_W + 1;
  localparam int MEM_W    = DATA_W + PAR_W;
  localparam bit USE_OREG = SINGLE_CLK && OUT_REG;

  logic              wr_rst_n, rd_rst_n;
  logic [PTR_W-1:0]  wptr_gray, rptr_gray, wptr_gray_rd, rptr_gray_wr;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [MEM_W-1:0]  ram_q, out_q;

  xclk_fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .arst_n(arst_n), .rst_n_o(wr_rst_n));
  xclk_fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .arst_n(arst_n), .rst_n_o(rd_rst_n));

  xclk_fifo_wr_ctl #(.ADDR_W(ADDR_W), .AFULL_GAP(AFULL_GAP)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_sync(rptr_gray_wr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .wgray(wptr_gray),
    .full(full), .almost_full(almost_full), .wr_count(wr_count), .wr_err(wr_err));

  xclk_fifo_rd_ctl #(.ADDR_W(ADDR_W), .AEMPTY_GAP(AEMPTY_GAP)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_sync(wptr_gray_rd),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .rgray(rptr_gray),
    .empty(empty), .almost_empty(almost_empty), .rd_count(rd_count), .rd_err(rd_err));

  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_rd));
  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_wr));

  xclk_fifo_ram #(.W(MEM_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata({wr_par, wr_data}),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(mem_re), .raddr(mem_raddr), .rdata(ram_q));

  xclk_fifo_ostage #(.W(MEM_W), .EN(USE_OREG)) u_ostage (
    .clk(rd_clk), .rst_n(rd_rst_n), .ce(oreg_ce), .srst(oreg_rst),
    .d(ram_q), .q(out_q));

  assign rd_data = out_q[DATA_W-1:0];
  assign rd_par  = out_q[MEM_W-1:DATA_W];
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              arst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              almost_full,
  input logic              empty,
  input logic              almost_empty,
  input logic              wr_err,
  input logic              rd_err,
  input logic [ADDR_W-1:0] wr_count,
  input logic [ADDR_W-1:0] rd_count,
  input logic [ADDR_W:0]   wptr_gray,
  input logic [ADDR_W:0]   rptr_gray
);
  p_full_write_dropped_r3: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (wr_en && full) |=> (wr_count == $past(wr_count)));

  p_wr_err_after_refused_r4: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (wr_en && full) |=> wr_err);

  p_wr_err_only_refused_r4: assert property (@(posedge wr_clk) disable iff (!arst_n)
    !(wr_en && full) |=> !wr_err);

  p_empty_read_dropped_r5: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (rd_en && empty) |=> (rd_err && rd_count == $past(rd_count)));

  p_rd_err_only_refused_r5: assert property (@(posedge rd_clk) disable iff (!arst_n)
    !(rd_en && empty) |=> !rd_err);

  p_full_has_afull_r6: assert property (@(posedge wr_clk) disable iff (!arst_n)
    full |-> almost_full);

  p_empty_has_aempty_r7: assert property (@(posedge rd_clk) disable iff (!arst_n)
    empty |-> almost_empty);

  p_wr_count_step_r8: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (wr_count == $past(wr_count)) || (wr_count == $past(wr_count) + ADDR_W'(1)));

  p_rd_count_step_r8: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + ADDR_W'(1)));

  p_wgray_one_bit_r9: assert property (@(posedge wr_clk) disable iff (!arst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  p_rgray_one_bit_r9: assert property (@(posedge rd_clk) disable iff (!arst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .almost_full(almost_full),
  .empty(empty), .almost_empty(almost_empty), .wr_err(wr_err), .rd_err(rd_err),
  .wr_count(wr_count), .rd_count(rd_count),
  .wptr_gray(wptr_gray), .rptr_gray(rptr_gray));

// File: tb/xclk_fifo_tb_top.sv
module xclk_fifo_tb_top;
  localparam int DATA_W = 16;
  localparam int PAR_W  = 2;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int AF     = 3;
  localparam int AE     = 5;
  localparam int W      = DATA_W + PAR_W;

  logic arst_n = 1'b0;
  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  always #5 wr_clk = ~wr_clk;   // 100 MHz
  always #7 rd_clk = ~rd_clk;

  logic              wr_en = 0, rd_en = 0, oreg_ce = 0, oreg_rst = 1;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [PAR_W-1:0]  wr_par = '0, rd_par;
  logic              full, almost_full, wr_err, empty, almost_empty, rd_err;
  logic [ADDR_W-1:0] wr_count, rd_count;

  // R11: dut_i holds oreg_rst high and oreg_ce low for the whole run
  xclk_fifo #(.DATA_W(DATA_W), .PAR_W(PAR_W), .ADDR_W(ADDR_W), .AFULL_GAP(AF),
              .AEMPTY_GAP(AE), .SYNC_STAGES(2), .SINGLE_CLK(1'b0), .OUT_REG(1'b1)) dut_i (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par),
    .full(full), .almost_full(almost_full), .wr_count(wr_count), .wr_err(wr_err),
    .rd_clk(rd_clk), .rd_en(rd_en), .oreg_ce(oreg_ce), .oreg_rst(oreg_rst),
    .rd_data(rd_data), .rd_par(rd_par), .empty(empty), .almost_empty(almost_empty),
    .rd_count(rd_count), .rd_err(rd_err));

  logic              r_wr_en = 0, r_rd_en = 0, r_ce = 0, r_rst = 0;
  logic [DATA_W-1:0] r_wr_data = '0, r_rd_data;
  logic [PAR_W-1:0]  r_wr_par = '0, r_rd_par;
  logic              r_full, r_afull, r_wr_err, r_empty, r_aempty, r_rd_err;
  logic [ADDR_W-1:0] r_wr_count, r_rd_count;

  xclk_fifo #(.DATA_W(DATA_W), .PAR_W(PAR_W), .ADDR_W(ADDR_W), .AFULL_GAP(AF),
              .AEMPTY_GAP(AE), .SYNC_STAGES(2), .SINGLE_CLK(1'b1), .OUT_REG(1'b1)) dut_reg_i (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(r_wr_en), .wr_data(r_wr_data), .wr_par(r_wr_par),
    .full(r_full), .almost_full(r_afull), .wr_count(r_wr_count), .wr_err(r_wr_err),
    .rd_clk(wr_clk), .rd_en(r_rd_en), .oreg_ce(r_ce), .oreg_rst(r_rst),
    .rd_data(r_rd_data), .rd_par(r_rd_par), .empty(r_empty), .almost_empty(r_aempty),
    .rd_count(r_rd_count), .rd_err(r_rd_err));

  int errors = 0;
  int checks = 0;
  logic [W-1:0] sbq [$];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one write attempt; expected word queued only when accepted
  task automatic wr_push(input logic [DATA_W-1:0] d, input logic [PAR_W-1:0] p, output bit acc);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d; wr_par = p;
    acc = !full;
    if (acc) sbq.push_back({p, d});
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  // monitor: one read attempt; accepted word compared one cycle later
  task automatic rd_pop(output bit acc);
    logic [W-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1'b1;
    acc = !empty;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (acc) begin
      if (sbq.size() == 0) check("R2", "read with empty scoreboard", 1, 0);
      else begin
        exp = sbq.pop_front();
        check("R2 R11", "read word", {rd_par, rd_data}, exp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    repeat (4) @(negedge wr_clk);
    arst_n = 1'b1;
    repeat (6) @(negedge rd_clk);

    // R1 reset state
    check("R1", "empty", empty, 1);
    check("R1", "almost_empty", almost_empty, 1);
    check("R1", "full", full, 0);
    check("R1", "almost_full", almost_full, 0);
    check("R1", "errors", {wr_err, rd_err}, 0);
    check("R1", "counts", {wr_count, rd_count}, 0);
    check("R1", "read word", {rd_par, rd_data}, 0);
    check("R1", "reg build read word", {r_rd_par, r_rd_data}, 0);

    // fill: R6 almost_full level, R8 count, R3 full
    for (int k = 1; k <= DEPTH; k++) begin
      wr_push(DATA_W'(16'h1000 + k), PAR_W'(k), acc);
      check("R6", "almost_full level", almost_full, ((DEPTH - k) < AF) ? 1 : 0);
      check("R8", "wr_count", wr_count, k % DEPTH);
    end
    check("R3", "full after depth writes", full, 1);

    // R3/R4: write while full dropped, error pulse for one cycle
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = 16'hDEAD; wr_par = 2'b11;
    @(negedge wr_clk);
    wr_en = 1'b0;
    check("R4", "wr_err after refused write", wr_err, 1);
    check("R3", "wr_count after refused write", wr_count, 0);
    @(negedge wr_clk);
    check("R4", "wr_err single cycle", wr_err, 0);

    // R9 empty clears after crossing
    repeat (8) @(negedge rd_clk);
    check("R9", "empty cleared after writes", empty, 0);

    // drain: R2 order, R7 level, R8 count
    for (int k = 1; k <= DEPTH; k++) begin
      rd_pop(acc);
      check("R7", "almost_empty level", almost_empty, ((DEPTH - k) < AE) ? 1 : 0);
      check("R8", "rd_count", rd_count, k % DEPTH);
    end
    check("R5", "empty after drain", empty, 1);
    check("R3", "no extra word stored", sbq.size(), 0);
    repeat (8) @(negedge wr_clk);
    check("R9", "full cleared after reads", full, 0);
    check("R9", "almost_full cleared after reads", almost_full, 0);

    // R5: read while empty dropped, error pulse for one cycle
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    check("R5", "rd_err after refused read", rd_err, 1);
    check("R5", "rd_count after refused read", rd_count, 0);
    @(negedge rd_clk);
    check("R5", "rd_err single cycle", rd_err, 0);

    // streaming with random gaps on both sides
    fork
      begin
        for (int i = 0; i < 48; i++) begin
          bit a;
          repeat ($urandom_range(0, 2)) @(negedge wr_clk);
          a = 1'b0;
          while (!a) wr_push(DATA_W'($urandom), PAR_W'($urandom), a);
        end
      end
      begin
        int got = 0;
        while (got < 48) begin
          bit a;
          repeat ($urandom_range(0, 3)) @(negedge rd_clk);
          rd_pop(a);
          if (a) got++;
        end
      end
    join
    check("R2", "scoreboard drained", sbq.size(), 0);

    // R10 output register build
    for (int i = 0; i < 2; i++) begin
      @(negedge wr_clk);
      r_wr_en = 1'b1; r_wr_data = (i == 0) ? 16'hA5A5 : 16'h5A5A; r_wr_par = (i == 0) ? 2'b01 : 2'b10;
    end
    @(negedge wr_clk);
    r_wr_en = 1'b0;
    repeat (6) @(negedge wr_clk);
    r_rd_en = 1'b1; r_ce = 1'b1;
    @(negedge wr_clk);
    r_rd_en = 1'b0;
    check("R10", "not yet after one cycle", {r_rd_par, r_rd_data}, 0);
    @(negedge wr_clk);
    check("R10", "word after two cycles", {r_rd_par, r_rd_data}, {2'b01, 16'hA5A5});
    r_ce = 1'b0; r_rd_en = 1'b1;
    @(negedge wr_clk);
    r_rd_en = 1'b0;
    check("R10", "hold with enable low", {r_rd_par, r_rd_data}, {2'b01, 16'hA5A5});
    @(negedge wr_clk);
    check("R10", "hold with enable low, second cycle", {r_rd_par, r_rd_data}, {2'b01, 16'hA5A5});
    r_ce = 1'b1; r_rst = 1'b1;
    @(negedge wr_clk);
    check("R10", "clear wins over enable", {r_rd_par, r_rd_data}, 0);
    r_rst = 1'b0;
    @(negedge wr_clk);
    check("R10", "next word after clear", {r_rd_par, r_rd_data}, {2'b10, 16'h5A5A});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule